// File: doc/BRIEF.md
# Control Store Image Loader

This block fills a writable microcode control store from a packed image held in 16-bit main memory. A start pulse loads a base pointer. The loader then reads the image three words at a time through a single-outstanding memory read port. Each three-word record yields a 12-bit control store address and a 36-bit microinstruction. The four lowest microinstruction bits travel in the low nibble of the address word. Each microinstruction goes into the control store in two consecutive strobed writes to the same address.

A record whose address field is all ones ends the load. That record is never written. It carries the entry point of the loaded code and a checksum. The loader presents both on outputs, pulses done for one cycle and, depending on a mode input, raises a jump request. The checksum is only reported; checking it is left to other logic. A continue input restarts loading from wherever the pointer stopped, without reloading the base, so that overlays placed back to back in memory can be brought in one after another.

Top module: `csload`

## Requirements
- R1: After synchronous reset the loader is idle: mem_req_o, cs_we_a_o, cs_we_b_o, done_o and jump_o are 0, and start_addr_o and checksum_o are 0.
- R2: A start_i pulse while idle loads base_i into the read pointer. Reads are issued at mem_addr_o = base, base+1, base+2 and so on. mem_req_o stays high until mem_valid_i, and a new address is presented only after the previous read was accepted.
- R3: For a normal record (word 0, word 1, word 2), the control store address is word0[15:4]. The first write is strobed by cs_we_a_o with cs_wdata_o = {word0[3:0], word1}, 20 bits.
- R4: The second write follows in the very next cycle, strobed by cs_we_b_o, at the same cs_addr_o, with cs_wdata_o = {4'b0000, word2}. cs_we_a_o and cs_we_b_o are never high together.
- R5: A record with word0[15:4] = 12'hFFF is the terminator and causes no control store write. done_o then pulses for exactly one cycle, start_addr_o takes its word 1 and checksum_o its word 2. Both hold until the next accepted start_i, which clears them to 0.
- R6: jump_o is high in the done_o cycle only if nojump_i was 0 when the terminator was decoded. jump_o is never high outside a done_o cycle.
- R7: A cont_i pulse while idle resumes reading at the address just past the last terminator read. start_addr_o and checksum_o are not cleared.
- R8: start_i and cont_i received while a load is in progress are ignored: the pointer, the writes and the result are those of the load already running.
- R9: Records are processed back to back with the pointer advancing by exactly one per accepted word. A terminator-only image completes with no control store writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load from base_i (idle only) |
| cont_i | input | 1 | Resume loading from the current pointer (idle only) |
| base_i | input | 16 | Image base address |
| nojump_i | input | 1 | 1 suppresses the jump request at the end of a load |
| mem_req_o | output | 1 | Read request, held until mem_valid_i |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 16 | Read data, valid with mem_valid_i |
| mem_valid_i | input | 1 | Read data valid, one pulse per request |
| cs_addr_o | output | 12 | Control store write address |
| cs_wdata_o | output | 20 | Control store write data for either half |
| cs_we_a_o | output | 1 | Strobe for the first half: word 1 plus four tail bits |
| cs_we_b_o | output | 1 | Strobe for the second half: word 2 |
| done_o | output | 1 | One-cycle pulse when the terminator is decoded |
| jump_o | output | 1 | Jump request, valid with done_o |
| start_addr_o | output | 16 | Start address from the terminator |
| checksum_o | output | 16 | Checksum from the terminator |

## Verification
Two events can fall in the same cycle: a start request, and the loader finishing, either through the done pulse or while it is still busy decoding and writing. The bench asserts start_i in the very cycle done_o is high. A start there must be accepted: the result outputs clear at once and a second image loads. A separate test pulses start_i and cont_i with a different base while a record is still being fetched. These must be ignored, which is judged from the read address sequence, the control store writes and the reported start address of the original image.

// File: rtl/csl_pkg.sv
package csl_pkg;
    parameter int WORD_W    = 16;
    parameter int CSA_W     = 12;
    parameter int TAIL_W    = 4;
    parameter int REC_WORDS = 3;

    localparam int INST_W  = 2 * WORD_W + TAIL_W;
    localparam int WDATA_W = WORD_W + TAIL_W;
    localparam int IDX_W   = $clog2(REC_WORDS);
    localparam logic [CSA_W-1:0] TERM_ADDR = '1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_WR_A,
        S_WR_B
    } state_t;

    typedef struct packed {
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } rec_t;

    function automatic logic [CSA_W-1:0] rec_addr(rec_t r);
        return r.w0[WORD_W-1 -: CSA_W];
    endfunction

    function automatic logic [TAIL_W-1:0] rec_tail(rec_t r);
        return r.w0[TAIL_W-1:0];
    endfunction

    function automatic logic rec_is_term(rec_t r);
        return rec_addr(r) == TERM_ADDR;
    endfunction
endpackage

// File: rtl/csl_ptr.sv
module csl_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= base;
        else if (inc)  ptr <= ptr + AW'(1);
    end
endmodule

// File: rtl/csl_asm.sv
module csl_asm
    import csl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap,
    input  logic [WORD_W-1:0] data,
    output logic              last,
    output rec_t              rec_o
);
    logic [IDX_W-1:0] idx;
    logic [REC_WORDS-1:0][WORD_W-1:0] words;

    assign last = (idx == IDX_W'(REC_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) idx <= '0;
        else if (cap)   idx <= last ? '0 : idx + IDX_W'(1);
    end

    for (genvar k = 0; k < REC_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                            q <= '0;
            else if (cap && idx == IDX_W'(k))   q <= data;
        end
        assign words[k] = q;
    end

    assign rec_o = rec_t'(words);
endmodule

// File: rtl/csl_ctl.sv
module csl_ctl
    import csl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cont,
    input  logic   mem_valid,
    input  logic   last,
    input  logic   term,
    output state_t state,
    output logic   ptr_load,
    output logic   ptr_inc,
    output logic   asm_clr,
    output logic   asm_cap,
    output logic   res_clr,
    output logic   res_load
);
    state_t nxt;

    always_comb begin
        nxt      = state;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        asm_clr  = 1'b0;
        asm_cap  = 1'b0;
        res_clr  = 1'b0;
        res_load = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    ptr_load = 1'b1;
                    asm_clr  = 1'b1;
                    res_clr  = 1'b1;
                    nxt      = S_FETCH;
                end else if (cont) begin
                    asm_clr  = 1'b1;
                    nxt      = S_FETCH;
                end
            end
            S_FETCH: begin
                if (mem_valid) begin
                    asm_cap = 1'b1;
                    ptr_inc = 1'b1;
                    if (last) nxt = S_DECODE;
                end
            end
            S_DECODE: begin
                if (term) begin
                    res_load = 1'b1;
                    nxt      = S_IDLE;
                end else begin
                    nxt      = S_WR_A;
                end
            end
            S_WR_A:  nxt = S_WR_B;
            S_WR_B:  nxt = S_FETCH;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/csload.sv
module csload
    import csl_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               cont_i,
    input  logic [MEM_AW-1:0]  base_i,
    input  logic               nojump_i,
    output logic               mem_req_o,
    output logic [MEM_AW-1:0]  mem_addr_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    input  logic               mem_valid_i,
    output logic [CSA_W-1:0]   cs_addr_o,
    output logic [WDATA_W-1:0] cs_wdata_o,
    output logic               cs_we_a_o,
    output logic               cs_we_b_o,
    output logic               done_o,
    output logic               jump_o,
    output logic [WORD_W-1:0]  start_addr_o,
    output logic [WORD_W-1:0]  checksum_o
);
    state_t state;
    rec_t   rec;
    logic   ptr_load, ptr_inc, asm_clr, asm_cap, res_clr, res_load, last;

    csl_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .cont      (cont_i),
        .mem_valid (mem_valid_i),
        .last      (last),
        .term      (rec_is_term(rec)),
        .state     (state),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .asm_clr   (asm_clr),
        .asm_cap   (asm_cap),
        .res_clr   (res_clr),
        .res_load  (res_load)
    );

    csl_ptr #(.AW(MEM_AW)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (ptr_load),
        .base (base_i),
        .inc  (ptr_inc),
        .ptr  (mem_addr_o)
    );

    csl_asm u_asm (
        .clk   (clk),
        .rst   (rst),
        .clr   (asm_clr),
        .cap   (asm_cap),
        .data  (mem_rdata_i),
        .last  (last),
        .rec_o (rec)
    );

    assign mem_req_o  = (state == S_FETCH);
    assign cs_we_a_o  = (state == S_WR_A);
    assign cs_we_b_o  = (state == S_WR_B);
    assign cs_addr_o  = rec_addr(rec);
    assign cs_wdata_o = (state == S_WR_B) ? {{TAIL_W{1'b0}}, rec.w2}
                                          : {rec_tail(rec), rec.w1};

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            jump_o       <= 1'b0;
            start_addr_o <= '0;
            checksum_o   <= '0;
        end else begin
            done_o <= res_load;
            jump_o <= res_load & ~nojump_i;
            if (res_clr) begin
                start_addr_o <= '0;
                checksum_o   <= '0;
            end else if (res_load) begin
                start_addr_o <= rec.w1;
                checksum_o   <= rec.w2;
            end
        end
    end
endmodule

// File: rtl/csl_chk.sv
module csl_chk #(
    parameter int MEM_AW = 16,
    parameter int CSA_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              we_a,
    input logic              we_b,
    input logic [CSA_W-1:0]  cs_addr,
    input logic              done,
    input logic              jump
);
    a_r5_no_term_write: assert property (@(posedge clk) disable iff (rst)
        (we_a || we_b) |-> cs_addr != {CSA_W{1'b1}});

    a_r4_a_then_b: assert property (@(posedge clk) disable iff (rst)
        we_a |=> we_b && cs_addr == $past(cs_addr));

    a_r4_b_after_a: assert property (@(posedge clk) disable iff (rst)
        we_b |-> $past(we_a));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_a, we_b}));

    a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid) |=> mem_addr == $past(mem_addr) + MEM_AW'(1));

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_jump_with_done: assert property (@(posedge clk) disable iff (rst)
        jump |-> done);
endmodule

bind csload csl_chk #(.MEM_AW(MEM_AW), .CSA_W(csl_pkg::CSA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req_o),
    .mem_valid (mem_valid_i),
    .mem_addr  (mem_addr_o),
    .we_a      (cs_we_a_o),
    .we_b      (cs_we_b_o),
    .cs_addr   (cs_addr_o),
    .done      (done_o),
    .jump      (jump_o)
);

// File: tb/sim_csload.sv
`timescale 1ns/1ps
module sim_csload;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, cont_i = 1'b0, nojump_i = 1'b0;
    logic [15:0] base_i = '0;
    logic        mem_req_o, mem_valid_i;
    logic [15:0] mem_addr_o, mem_rdata_i;
    logic [11:0] cs_addr_o;
    logic [19:0] cs_wdata_o;
    logic        cs_we_a_o, cs_we_b_o, done_o, jump_o;
    logic [15:0] start_addr_o, checksum_o;

    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    csload u0 (.*);

    // memory model: one read at a time, data one cycle after request seen
    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (rst) mem_valid_i <= 1'b0;
        else     mem_valid_i <= mem_req_o && !mem_valid_i;
        mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    // observers of the write port and read sequence
    logic [19:0] wa [0:4095];
    logic [15:0] wb [0:4095];
    int n_wa, n_wb, n_wfff, seq_err, n_rd;
    logic [15:0] exp_rd;
    always @(negedge clk) begin
        if (cs_we_a_o) begin
            wa[cs_addr_o] = cs_wdata_o;
            n_wa++;
            if (cs_addr_o == 12'hFFF) n_wfff++;
        end
        if (cs_we_b_o) begin
            wb[cs_addr_o] = cs_wdata_o[15:0];
            n_wb++;
            if (cs_addr_o == 12'hFFF) n_wfff++;
        end
        if (mem_req_o && mem_valid_i) begin
            if (mem_addr_o != exp_rd) seq_err++;
            exp_rd = mem_addr_o + 16'd1;
            n_rd++;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_log(logic [15:0] first);
        n_wa = 0; n_wb = 0; n_wfff = 0; seq_err = 0; n_rd = 0;
        exp_rd = first;
    endtask

    task automatic put_rec(int p, logic [11:0] a, logic [3:0] t,
                           logic [15:0] w1, logic [15:0] w2);
        mem[p] = {a, t}; mem[p+1] = w1; mem[p+2] = w2;
    endtask

    task automatic pulse_start(logic [15:0] b);
        @(negedge clk);
        base_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle outputs", {mem_req_o, cs_we_a_o, cs_we_b_o, done_o, jump_o}, 0);
        chk("R1 start_addr", start_addr_o, 0);
        chk("R1 checksum", checksum_o, 0);
    endtask

    task automatic t_basic();
        bit ok;
        put_rec(16'h10, 12'h123, 4'hA, 16'h1111, 16'h2222);
        put_rec(16'h13, 12'h000, 4'h5, 16'hBEEF, 16'hCAFE);
        put_rec(16'h16, 12'hFFE, 4'hF, 16'h0F0F, 16'hF0F0);
        put_rec(16'h19, 12'hFFF, 4'h7, 16'h0456, 16'h9ABC);
        nojump_i = 1'b0;
        clear_log(16'h10);
        pulse_start(16'h10);
        wait_done(ok);
        chk("R5 done seen", ok, 1);
        chk("R6 jump with nojump=0", jump_o, 1);
        chk("R5 start address", start_addr_o, 16'h0456);
        chk("R5 checksum", checksum_o, 16'h9ABC);
        chk("R3 first half rec0", wa[12'h123], 20'hA1111);
        chk("R4 second half rec0", wb[12'h123], 16'h2222);
        chk("R3 first half addr 0", wa[12'h000], 20'h5BEEF);
        chk("R4 second half addr 0", wb[12'h000], 16'hCAFE);
        chk("R3 first half top addr", wa[12'hFFE], 20'hF0F0F);
        chk("R4 second half top addr", wb[12'hFFE], 16'hF0F0);
        chk("R4 write counts", {n_wa[15:0], n_wb[15:0]}, {16'd3, 16'd3});
        chk("R5 terminator not written", n_wfff, 0);
        chk("R2 R9 read sequence", seq_err, 0);
        chk("R9 words read", n_rd, 12);
        @(negedge clk);
        chk("R5 done one cycle", done_o, 0);
        chk("R6 jump one cycle", jump_o, 0);
        repeat (8) @(negedge clk);
        chk("R5 start address held", start_addr_o, 16'h0456);
        chk("R5 checksum held", checksum_o, 16'h9ABC);
    endtask

    task automatic t_nojump();
        bit ok;
        put_rec(16'h40, 12'h321, 4'h3, 16'h1234, 16'h5678);
        put_rec(16'h43, 12'hFFF, 4'h0, 16'h0077, 16'h0088);
        nojump_i = 1'b1;
        clear_log(16'h40);
        pulse_start(16'h40);
        wait_done(ok);
        chk("R5 done with nojump", ok, 1);
        chk("R6 no jump when nojump=1", jump_o, 0);
        chk("R5 start address nojump", start_addr_o, 16'h0077);
        chk("R3 nojump record", wa[12'h321], 20'h31234);
        nojump_i = 1'b0;
    endtask

    task automatic t_continue();
        bit ok;
        put_rec(16'h60, 12'h010, 4'h1, 16'hAAAA, 16'hBBBB);
        put_rec(16'h63, 12'hFFF, 4'h0, 16'h0011, 16'h00C1);
        put_rec(16'h66, 12'h020, 4'h2, 16'hCCCC, 16'hDDDD);
        put_rec(16'h69, 12'hFFF, 4'h0, 16'h0022, 16'h00C2);
        clear_log(16'h60);
        pulse_start(16'h60);
        wait_done(ok);
        chk("R7 first overlay start", start_addr_o, 16'h0011);
        clear_log(16'h66);
        @(negedge clk);
        cont_i = 1'b1;
        @(negedge clk);
        cont_i = 1'b0;
        chk("R7 result kept on continue", start_addr_o, 16'h0011);
        wait_done(ok);
        chk("R7 second overlay done", ok, 1);
        chk("R7 second overlay start", start_addr_o, 16'h0022);
        chk("R7 second overlay write", wa[12'h020], 20'h2CCCC);
        chk("R7 reads resume after terminator", seq_err, 0);
    endtask

    task automatic t_busy();
        bit ok;
        put_rec(16'h80, 12'h030, 4'h9, 16'h3030, 16'h4040);
        put_rec(16'h83, 12'hFFF, 4'h0, 16'h0033, 16'h0003);
        put_rec(16'hA0, 12'h050, 4'h6, 16'h5050, 16'h6060);
        put_rec(16'hA3, 12'hFFF, 4'h0, 16'h0044, 16'h0004);
        wa[12'h050] = '0;
        clear_log(16'h80);
        pulse_start(16'h80);
        repeat (2) @(negedge clk);
        base_i = 16'hA0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; cont_i = 1'b1;
        @(negedge clk);
        cont_i = 1'b0;
        wait_done(ok);
        chk("R8 busy load done", ok, 1);
        chk("R8 start ignored while busy", start_addr_o, 16'h0033);
        chk("R8 reads not redirected", seq_err, 0);
        chk("R8 other image not written", wa[12'h050], 0);
        chk("R8 own record written", wa[12'h030], 20'h93030);
    endtask

    task automatic t_start_at_done();
        bit ok;
        clear_log(16'h80);
        pulse_start(16'h80);
        wait_done(ok);
        chk("R5 first done", start_addr_o, 16'h0033);
        base_i = 16'hA0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R5 start clears result", {start_addr_o, checksum_o}, 0);
        wait_done(ok);
        chk("R2 start in done cycle accepted", ok, 1);
        chk("R2 second image start", start_addr_o, 16'h0044);
        chk("R3 second image write", wa[12'h050], 20'h65050);
    endtask

    task automatic t_term_only();
        bit ok;
        put_rec(16'hC0, 12'hFFF, 4'hE, 16'h0055, 16'h0505);
        clear_log(16'hC0);
        pulse_start(16'hC0);
        wait_done(ok);
        chk("R9 terminator-only done", ok, 1);
        chk("R9 no writes", {n_wa[15:0], n_wb[15:0]}, 0);
        chk("R9 terminator-only reads", n_rd, 3);
        chk("R5 checksum terminator-only", checksum_o, 16'h0505);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 4096; i++) begin wa[i] = '0; wb[i] = '0; end
        clear_log(16'h0);
        t_reset();
        t_basic();
        t_nojump();
        t_continue();
        t_busy();
        t_start_at_done();
        t_term_only();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule